// File: doc/BRIEF.md
# DDR3 Power-Up Command Sequencer

This block drives the fixed DDR3 device initialization commands into a memory controller's single-entry command register once the controller has finished power-up. A start pulse captures four 13-bit mode-register values. The block then issues seven commands in order: DESELECT, PRECHARGE-ALL, four mode-register writes, and a long ZQ calibration. Every command addresses both chip selects.

Each command is presented as one 32-bit word on `cmd_word_o`. Bit 31 of the word is a start flag. The block sets it when it issues a command. The accepting side pulses `cmd_ack_i` to clear it. One cycle after the flag clears, the block issues the next word. When the seventh command has been accepted, the block raises a done flag, and that flag stays high until the next start pulse is taken.

Top module: `ddr3i_seq_top`

## Requirements
- R1: While reset is asserted, and right after it, `cmd_word_o` is all zeros and `busy_o` and `done_o` are low. Asserting reset in the middle of a sequence clears the outputs at once.
- R2: The opcode sits in bits [3:0] and the commands are issued in this order: DESELECT (0), PRECHARGE-ALL (1), MRS (3) four times, then ZQCL (4).
- R3: Bits [21:20] of every issued word carry the rank value 3, meaning both chip selects. Bits [30:22] are zero.
- R4: Bits [19:17] hold the bank field. For the four MRS commands it carries the mode-register numbers 2, 3, 1, 0 in issue order. The non-MRS commands carry 0 in both the bank field and the address field.
- R5: Bits [16:4] hold the 13-bit address field. The MRS commands to MR2, MR3 and MR1 carry the captured `mr2_i`, `mr3_i` and `mr1_i` values unchanged.
- R6: The MRS command to MR0 carries the captured `mr0_i` value with address bit 8 (word bit 12) forced to 1, which is the DLL reset bit.
- R7: The start flag (bit 31) of an issued word stays 1, and the word stays unchanged, until a cycle with `cmd_ack_i` high. In the cycle after that, bit 31 reads 0 and the other bits are unchanged. The next command appears, with bit 31 set, one cycle later.
- R8: A `cmd_ack_i` pulse while the start flag is 0 has no effect. It does not clear the next command's flag, and it does not change the word or `done_o` while the block is idle.
- R9: `start_i` is ignored while `busy_o` is high. The mode-register inputs are captured only when a start pulse is accepted, so changing them during a sequence does not alter the words.
- R10: `busy_o` rises in the cycle after an accepted start and `done_o` falls in that same cycle. When the seventh command is accepted, `busy_o` falls and `done_o` rises. `done_o` stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Starts a sequence when the block is idle |
| mr0_i | input | 13 | MR0 value |
| mr1_i | input | 13 | MR1 value |
| mr2_i | input | 13 | MR2 value |
| mr3_i | input | 13 | MR3 value |
| cmd_ack_i | input | 1 | Accept pulse from the command register; clears the start flag |
| cmd_word_o | output | 32 | Command word with start flag, rank, bank, address and opcode |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | The last sequence has completed |

## Verification
The sequence is run with four sets of mode-register values:
- All ones, where the forced DLL reset bit is already set.
- All zeros, where it must appear on its own.
- Alternating bit patterns, which expose swapped or shifted address bits.
- Four distinct values, which reveal whether MR1, MR2 and MR3 have been placed into the wrong words.

The accept latency varies from command to command, including zero wait cycles, and this separates a design that truly holds each word from one that advances on a timer. Three further patterns are also tried:
- A double accept pulse that overlaps the gap cycle.
- A start pulse with changed mode-register inputs in the middle of a sequence.
- Accept pulses while the block is idle.

These show that stray inputs are ignored.

// File: rtl/ddr3i_pkg.sv
package ddr3i_pkg;

  localparam int OP_W     = 4;
  localparam int ADDR_W   = 13;
  localparam int BANK_W   = 3;
  localparam int RANK_W   = 2;
  localparam int WORD_W   = 32;
  localparam int RSVD_W   = WORD_W - 1 - RANK_W - BANK_W - ADDR_W - OP_W;
  localparam int NUM_CMDS = 7;
  localparam int NUM_MR   = 4;
  localparam int STEP_W   = $clog2(NUM_CMDS);

  typedef enum logic [OP_W-1:0] {
    OP_DESEL = 4'd0,
    OP_PREA  = 4'd1,
    OP_REF   = 4'd2,
    OP_MRS   = 4'd3,
    OP_ZQCL  = 4'd4
  } op_e;

  typedef struct packed {
    logic              start;
    logic [RSVD_W-1:0] rsvd;
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
    op_e               op;
  } cmd_word_t;

endpackage

// File: rtl/ddr3i_rst_sync.sv
module ddr3i_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ddr3i_step_ctrl.sv
module ddr3i_step_ctrl
  import ddr3i_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              taken_i,
  output logic [STEP_W-1:0] step_o,
  output logic              load_o,
  output logic              capture_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_CMDS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT} state_e;

  state_e            state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    done_d    = done_q;
    load_o    = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          capture_o = 1'b1;
          step_d    = '0;
          done_d    = 1'b0;
          state_d   = ST_LOAD;
        end
      end
      ST_LOAD: begin
        load_o  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (taken_i) begin
          if (step_q == LAST_STEP) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            step_d  = step_q + 1'b1;
            state_d = ST_LOAD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  assign step_o = step_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // R2: the step counter never runs past the last command
  a_r2_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST_STEP);

  // R10: done and an active sequence never overlap
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE));

  // R9: a start pulse during a sequence does not restart it
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !taken_i) |=> (state_q == ST_WAIT && $stable(step_q)));
endmodule

// File: rtl/ddr3i_cmd_rom.sv
module ddr3i_cmd_rom
  import ddr3i_pkg::*;
#(
  parameter int RANK_SEL    = 3,
  parameter int DLL_RST_BIT = 8
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] mr_i [NUM_MR],
  output cmd_word_t         word_o
);
  localparam logic [ADDR_W-1:0] DLL_RST_MASK = ADDR_W'(1) << DLL_RST_BIT;

  always_comb begin
    word_o      = '0;
    word_o.op   = OP_DESEL;
    word_o.rank = RANK_W'(RANK_SEL);
    unique case (step_i)
      STEP_W'(0): word_o.op = OP_DESEL;
      STEP_W'(1): word_o.op = OP_PREA;
      STEP_W'(2): begin
        word_o.op   = OP_MRS;
        word_o.bank = BANK_W'(2);
        word_o.addr = mr_i[2];
      end
      STEP_W'(3): begin
        word_o.op   = OP_MRS;
        word_o.bank = BANK_W'(3);
        word_o.addr = mr_i[3];
      end
      STEP_W'(4): begin
        word_o.op   = OP_MRS;
        word_o.bank = BANK_W'(1);
        word_o.addr = mr_i[1];
      end
      STEP_W'(5): begin
        word_o.op   = OP_MRS;
        word_o.bank = BANK_W'(0);
        word_o.addr = mr_i[0] | DLL_RST_MASK;
      end
      STEP_W'(6): word_o.op = OP_ZQCL;
      default:    word_o.op = OP_DESEL;
    endcase
  end
endmodule

// File: rtl/ddr3i_cmd_reg.sv
module ddr3i_cmd_reg
  import ddr3i_pkg::*;
#(
  parameter int RANK_SEL    = 3,
  parameter int DLL_RST_BIT = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  cmd_word_t word_i,
  input  logic      ack_i,
  output cmd_word_t word_o,
  output logic      taken_o
);
  cmd_word_t word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load_i) begin
      word_d       = word_i;
      word_d.start = 1'b1;
    end else if (word_q.start && ack_i) begin
      word_d.start = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word_o  = word_q;
  assign taken_o = word_q.start & ack_i & ~load_i;

  // R7: a pending command is held unchanged until accepted
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_q.start && !ack_i) |=> (word_q.start && $stable(word_q)));

  // R7: an accept clears the flag and leaves the rest of the word alone
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_q.start && ack_i) |=> (!word_q.start && word_q[WORD_W-2:0] == $past(word_q[WORD_W-2:0])));

  // R3: issued words address both ranks and keep reserved bits zero
  a_r3_rank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_q.start |-> (word_q.rank == RANK_W'(RANK_SEL) && word_q.rsvd == '0));

  // R6: the write to mode register 0 carries the DLL reset bit
  a_r6_dll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_q.start && word_q.op == OP_MRS && word_q.bank == '0) |-> word_q.addr[DLL_RST_BIT]);

  // R4: non-MRS commands carry no bank or address
  a_r4_plain_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_q.start && word_q.op != OP_MRS) |-> (word_q.bank == '0 && word_q.addr == '0));
endmodule

// File: rtl/ddr3i_seq_top.sv
module ddr3i_seq_top
  import ddr3i_pkg::*;
#(
  parameter int RANK_SEL    = 3,
  parameter int DLL_RST_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] mr0_i,
  input  logic [ADDR_W-1:0] mr1_i,
  input  logic [ADDR_W-1:0] mr2_i,
  input  logic [ADDR_W-1:0] mr3_i,
  input  logic              cmd_ack_i,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              rst_n_s;
  logic [STEP_W-1:0] step;
  logic              load, capture, taken;
  logic [ADDR_W-1:0] mr_in [NUM_MR];
  logic [ADDR_W-1:0] mr_q  [NUM_MR];
  cmd_word_t         rom_word, reg_word;

  ddr3i_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  assign mr_in[0] = mr0_i;
  assign mr_in[1] = mr1_i;
  assign mr_in[2] = mr2_i;
  assign mr_in[3] = mr3_i;

  for (genvar g = 0; g < NUM_MR; g++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_n_s) begin
      if (!rst_n_s)     mr_q[g] <= '0;
      else if (capture) mr_q[g] <= mr_in[g];
    end

    // R9: captured mode-register values are frozen during a sequence
    a_r9_mr_hold: assert property (@(posedge clk_i) disable iff (!rst_n_s)
      busy_o |=> $stable(mr_q[g]));
  end

  ddr3i_step_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .start_i  (start_i),
    .taken_i  (taken),
    .step_o   (step),
    .load_o   (load),
    .capture_o(capture),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  ddr3i_cmd_rom #(.RANK_SEL(RANK_SEL), .DLL_RST_BIT(DLL_RST_BIT)) u_rom (
    .step_i(step),
    .mr_i  (mr_q),
    .word_o(rom_word)
  );

  ddr3i_cmd_reg #(.RANK_SEL(RANK_SEL), .DLL_RST_BIT(DLL_RST_BIT)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .load_i (load),
    .word_i (rom_word),
    .ack_i  (cmd_ack_i),
    .word_o (reg_word),
    .taken_o(taken)
  );

  assign cmd_word_o = reg_word;

  // R10: done rises only on the acceptance of a command
  a_r10_done_rise: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(done_o) |-> !reg_word.start);
endmodule

// File: tb/ddr3i_seq_top_tb_top.sv
module ddr3i_seq_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [12:0] mr0_i, mr1_i, mr2_i, mr3_i;
  logic        cmd_ack_i;
  logic [31:0] cmd_word_o;
  logic        busy_o, done_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  ddr3i_seq_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mr0_i(mr0_i), .mr1_i(mr1_i), .mr2_i(mr2_i), .mr3_i(mr3_i),
    .cmd_ack_i(cmd_ack_i), .cmd_word_o(cmd_word_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [12:0] m0, m1, m2, m3;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{13'h1fff, 13'h1fff, 13'h1fff, 13'h1fff, 4'd0},
    '{13'h0000, 13'h0000, 13'h0000, 13'h0000, 4'd1},
    '{13'h1555, 13'h0aaa, 13'h1555, 13'h0aaa, 4'd2},
    '{13'h0420, 13'h0042, 13'h0018, 13'h0003, 4'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int k, input vec_t v);
    logic [3:0]  op;
    logic [2:0]  bank;
    logic [12:0] addr;
    op = 4'd0; bank = 3'd0; addr = 13'd0;
    case (k)
      0: op = 4'd0;
      1: op = 4'd1;
      2: begin op = 4'd3; bank = 3'd2; addr = v.m2; end
      3: begin op = 4'd3; bank = 3'd3; addr = v.m3; end
      4: begin op = 4'd3; bank = 3'd1; addr = v.m1; end
      5: begin op = 4'd3; bank = 3'd0; addr = v.m0 | 13'h0100; end
      default: op = 4'd4;
    endcase
    return {1'b1, 9'd0, 2'd3, bank, addr, op};
  endfunction

  task automatic run_seq(input vec_t v, input bit dbl, input bit disturb);
    logic [31:0] e;
    mr0_i = v.m0; mr1_i = v.m1; mr2_i = v.m2; mr3_i = v.m3;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10 busy after start", {31'd0, busy_o}, 32'd1);
    chk("R10 done falls on start", {31'd0, done_o}, 32'd0);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_i);
      e = exp_word(k, v);
      chk($sformatf("R2 R3 R4 R5 R6 word %0d", k), cmd_word_o, e);
      if (disturb && k == 2) begin
        mr0_i = ~v.m0; mr1_i = ~v.m1; mr2_i = ~v.m2; mr3_i = ~v.m3;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        chk("R9 start ignored while busy", cmd_word_o, e);
      end
      for (int j = 0; j < int'((v.lat + 4'(k)) % 4); j++) begin
        @(negedge clk_i);
        chk($sformatf("R7 held word %0d", k), cmd_word_o, e);
      end
      cmd_ack_i = 1'b1;
      @(negedge clk_i);
      chk($sformatf("R7 flag cleared word %0d", k), cmd_word_o, {1'b0, e[30:0]});
      if (!(dbl && k == 3)) cmd_ack_i = 1'b0;
      if (k == 6) begin
        chk("R10 done at end", {31'd0, done_o}, 32'd1);
        chk("R10 busy low at end", {31'd0, busy_o}, 32'd0);
      end
      if (dbl && k == 3) begin
        @(negedge clk_i);
        cmd_ack_i = 1'b0;
        chk("R8 ack in gap ignored", cmd_word_o, exp_word(4, v));
        @(negedge clk_i);
        chk("R8 next flag still set", cmd_word_o, exp_word(4, v));
        for (int j = 0; j < int'((v.lat + 4'd4) % 4); j++) @(negedge clk_i);
        cmd_ack_i = 1'b1;
        @(negedge clk_i);
        cmd_ack_i = 1'b0;
        chk("R7 flag cleared word 4", cmd_word_o, {1'b0, exp_word(4, v)[30:0]});
        k = 4;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL R10 watchdog actual=not_done expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] last;
    rst_ni = 1'b0; start_i = 1'b0; cmd_ack_i = 1'b0;
    mr0_i = '0; mr1_i = '0; mr2_i = '0; mr3_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset word", cmd_word_o, 32'd0);
    chk("R1 reset busy", {31'd0, busy_o}, 32'd0);
    chk("R1 reset done", {31'd0, done_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 word after release", cmd_word_o, 32'd0);

    for (int v = 0; v < 4; v++) run_seq(VECS[v], v == 1, v == 2);

    last = {1'b0, exp_word(6, VECS[3])[30:0]};
    cmd_ack_i = 1'b1;
    repeat (2) @(negedge clk_i);
    cmd_ack_i = 1'b0;
    @(negedge clk_i);
    chk("R8 idle ack word", cmd_word_o, last);
    chk("R8 R10 done held", {31'd0, done_o}, 32'd1);
    repeat (5) @(negedge clk_i);
    chk("R10 done still held", {31'd0, done_o}, 32'd1);

    run_seq(VECS[2], 1'b0, 1'b0);

    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 mid-sequence reset word", cmd_word_o, 32'd0);
    chk("R1 mid-sequence reset busy", {31'd0, busy_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule